// File: doc/BRIEF.md
# Asynchronous Parallel Slave Port

This block lets an external microprocessor exchange bytes with a local CPU through one shared 8-bit data latch. The external side drives three active-low strobes: select, read and write. It sees the latch through a bidirectional byte bus, which is split here into an input byte, an output byte and an output-enable. The local side reads and writes the same latch through a simple register port. It watches two handshake flags: input-full, meaning the external master wrote a byte the CPU has not yet read, and output-full, meaning the CPU wrote a byte the external master has not yet read. It also watches an interrupt flag that is raised whenever an external transfer is released.

The strobes and the input byte arrive with no relation to the local clock. They pass through a two-flop synchroniser before any decision is taken. A transfer is framed by the synchronised strobe levels: it begins when select and a direction strobe are both seen low, and it ends when either one is seen high. Slave operation needs a mode-enable input. It is also held off while a sibling PWM unit reports that it owns the pins in a multi-output mode.

Top module: `pslave_port`

## Requirements
- R1: After reset, in_full, out_full, overflow and irq are 0 and ext_data_oe is 0.
- R2: No transfer starts unless mode_en is 1 and pwm_busy is 0; an idle strobe pattern under those conditions changes neither the latch, the flags nor the bus.
- R3: An external write begins when sel_n and wr_n are both seen low and ends when either is seen high. At its end the latch takes the byte last seen on ext_data_in while the strobes were low, and in_full and irq are set.
- R4: An external read begins when sel_n and rd_n are both seen low. From the next clock ext_data_oe is 1 with the latch on ext_data_out, and out_full is cleared.
- R5: A read ends when sel_n or rd_n is seen high; ext_data_oe then returns to 0 and irq is set on the same clock.
- R6: A cpu_wr pulse writes cpu_wdata into the latch. Outside a read it sets out_full; during a read the new byte appears on ext_data_out at once and out_full stays 0.
- R7: cpu_rdata always shows the latch, and a cpu_rd pulse clears in_full.
- R8: A write that ends while in_full is still 1 sets overflow, and its byte still replaces the latch. overflow stays set until an ovf_clr pulse.
- R9: Strobes and input data pass through two synchroniser flops. A strobe level present at clock edge k governs the transfer state updated at edge k+2.
- R10: irq stays set until an irq_clr pulse. A new transfer end on the same clock as irq_clr leaves it set.
- R11: If wr_n and rd_n are both seen low under sel_n when a transfer starts, it is a write and ext_data_oe stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | Slave mode enable |
| pwm_busy | input | 1 | High while a dual or quad output PWM mode owns the pins |
| ext_sel_n | input | 1 | External chip select, active low |
| ext_rd_n | input | 1 | External read strobe, active low |
| ext_wr_n | input | 1 | External write strobe, active low |
| ext_data_in | input | 8 | Byte from the external bus |
| ext_data_out | output | 8 | Byte driven onto the external bus |
| ext_data_oe | output | 1 | External bus output enable |
| cpu_wr | input | 1 | Local write pulse |
| cpu_wdata | input | 8 | Local write byte |
| cpu_rd | input | 1 | Local read pulse (acknowledges input-full) |
| cpu_rdata | output | 8 | Latch contents |
| irq_clr | input | 1 | Clears the interrupt flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| in_full | output | 1 | Unread external byte present |
| out_full | output | 1 | Byte waiting for the external master |
| overflow | output | 1 | Sticky write-over-unread flag |
| irq | output | 1 | Transfer-release interrupt flag |

## Verification
Any corruption of the transfer state shows at the ports within one clock as a wrong ext_data_oe or a missing or extra flag. A latch error shows at once on cpu_rdata. The reference model tracks the synchroniser delay, so a state that advances one edge early or late is reported on the first clock where it diverges. A wrong flag priority appears as a flag mismatch on the clock right after the colliding pulses.

// File: rtl/psp_pkg.sv
package psp_pkg;

    localparam int DATA_W      = 8;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_WRITE = 2'd1,
        CYC_READ  = 2'd2
    } cyc_state_e;

    typedef struct packed {
        logic sel_n;
        logic rd_n;
        logic wr_n;
    } strobe_t;

    typedef struct packed {
        logic wr_end;
        logic rd_start;
        logic rd_end;
        logic rd_busy;
        logic wr_hold;
    } cyc_evt_t;

    function automatic logic both_low(input logic a_n, input logic b_n);
        return !a_n && !b_n;
    endfunction

endpackage

// File: rtl/psp_sync.sv
module psp_sync #(
    parameter int WIDTH  = 11,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= din;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/psp_cycle_fsm.sv
module psp_cycle_fsm
    import psp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  strobe_t  stb,
    output cyc_evt_t evt
);

    cyc_state_e state, state_nxt;
    logic wr_lvl, rd_lvl;

    assign wr_lvl = both_low(stb.sel_n, stb.wr_n);
    assign rd_lvl = both_low(stb.sel_n, stb.rd_n);

    always_comb begin
        state_nxt    = state;
        evt.wr_end   = 1'b0;
        evt.rd_start = 1'b0;
        evt.rd_end   = 1'b0;
        unique case (state)
            CYC_IDLE: begin
                if (enable && wr_lvl) begin
                    state_nxt = CYC_WRITE;
                end else if (enable && rd_lvl) begin
                    state_nxt    = CYC_READ;
                    evt.rd_start = 1'b1;
                end
            end
            CYC_WRITE: begin
                if (!wr_lvl) begin
                    state_nxt  = CYC_IDLE;
                    evt.wr_end = 1'b1;
                end
            end
            CYC_READ: begin
                if (!rd_lvl) begin
                    state_nxt  = CYC_IDLE;
                    evt.rd_end = 1'b1;
                end
            end
            default: state_nxt = CYC_IDLE;
        endcase
        evt.rd_busy = (state == CYC_READ);
        evt.wr_hold = (state_nxt == CYC_WRITE);
    end

    always_ff @(posedge clk) begin
        if (rst) state <= CYC_IDLE;
        else     state <= state_nxt;
    end

    assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (state == CYC_IDLE && !enable) |=> (state == CYC_IDLE));

    assert_write_priority_R11: assert property (@(posedge clk) disable iff (rst)
        (state == CYC_IDLE && enable && wr_lvl && rd_lvl) |=> (state == CYC_WRITE));

endmodule

// File: rtl/psp_flags.sv
module psp_flags
    import psp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cyc_evt_t evt,
    input  logic     cpu_wr,
    input  logic     cpu_rd,
    input  logic     irq_clr,
    input  logic     ovf_clr,
    output logic     in_full,
    output logic     out_full,
    output logic     overflow,
    output logic     irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_full  <= 1'b0;
            out_full <= 1'b0;
            overflow <= 1'b0;
            irq      <= 1'b0;
        end else begin
            if (evt.wr_end)  in_full <= 1'b1;
            else if (cpu_rd) in_full <= 1'b0;

            if (evt.rd_start)                  out_full <= 1'b0;
            else if (cpu_wr && !evt.rd_busy)   out_full <= 1'b1;

            if (evt.wr_end && in_full) overflow <= 1'b1;
            else if (ovf_clr)          overflow <= 1'b0;

            if (evt.wr_end || evt.rd_end) irq <= 1'b1;
            else if (irq_clr)             irq <= 1'b0;
        end
    end

    assert_write_sets_flags_R3: assert property (@(posedge clk) disable iff (rst)
        evt.wr_end |=> (in_full && irq));

    assert_read_clears_obf_R4: assert property (@(posedge clk) disable iff (rst)
        evt.rd_start |=> !out_full);

    assert_obf_held_in_read_R6: assert property (@(posedge clk) disable iff (rst)
        (evt.rd_busy && !out_full && cpu_wr) |=> !out_full);

    assert_no_overflow_loss_R8: assert property (@(posedge clk) disable iff (rst)
        (overflow && !ovf_clr) |=> overflow);

    assert_irq_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

endmodule

// File: rtl/pslave_port.sv
module pslave_port
    import psp_pkg::*;
#(
    parameter int DW     = psp_pkg::DATA_W,
    parameter int STAGES = psp_pkg::SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_en,
    input  logic          pwm_busy,
    input  logic          ext_sel_n,
    input  logic          ext_rd_n,
    input  logic          ext_wr_n,
    input  logic [DW-1:0] ext_data_in,
    output logic [DW-1:0] ext_data_out,
    output logic          ext_data_oe,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_rd,
    output logic [DW-1:0] cpu_rdata,
    input  logic          irq_clr,
    input  logic          ovf_clr,
    output logic          in_full,
    output logic          out_full,
    output logic          overflow,
    output logic          irq
);

    localparam int SW = $bits(strobe_t);
    localparam int VW = SW + DW;
    localparam logic [VW-1:0] SYNC_RST = {{SW{1'b1}}, {DW{1'b0}}};

    logic [VW-1:0] raw_vec, sync_vec;
    strobe_t       stb_s;
    logic [DW-1:0] data_s;
    cyc_evt_t      evt;
    logic [DW-1:0] latch_q, wr_buf_q;
    logic          oe_q;
    logic          enable;

    assign raw_vec = {ext_sel_n, ext_rd_n, ext_wr_n, ext_data_in};
    assign enable  = mode_en && !pwm_busy;

    psp_sync #(.WIDTH(VW), .STAGES(STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_vec),
        .dout (sync_vec)
    );

    assign stb_s  = strobe_t'(sync_vec[VW-1:DW]);
    assign data_s = sync_vec[DW-1:0];

    psp_cycle_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .stb    (stb_s),
        .evt    (evt)
    );

    psp_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .cpu_wr   (cpu_wr),
        .cpu_rd   (cpu_rd),
        .irq_clr  (irq_clr),
        .ovf_clr  (ovf_clr),
        .in_full  (in_full),
        .out_full (out_full),
        .overflow (overflow),
        .irq      (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q  <= '0;
            wr_buf_q <= '0;
            oe_q     <= 1'b0;
        end else begin
            if (evt.wr_hold) wr_buf_q <= data_s;
            if (evt.wr_end)  latch_q  <= wr_buf_q;
            else if (cpu_wr) latch_q  <= cpu_wdata;
            oe_q <= (evt.rd_start || evt.rd_busy) && !evt.rd_end;
        end
    end

    assign ext_data_oe  = oe_q;
    assign ext_data_out = latch_q;
    assign cpu_rdata    = latch_q;

    assert_release_irq_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ext_data_oe) |-> irq);

    assert_oe_not_in_write_R11: assert property (@(posedge clk) disable iff (rst)
        evt.wr_hold |=> !ext_data_oe);

endmodule

// File: tb/pslave_port_tb.sv
module pslave_port_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       mode_en, pwm_busy;
    logic       ext_sel_n, ext_rd_n, ext_wr_n;
    logic [7:0] ext_data_in, ext_data_out, cpu_wdata, cpu_rdata;
    logic       ext_data_oe, cpu_wr, cpu_rd, irq_clr, ovf_clr;
    logic       in_full, out_full, overflow, irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pslave_port u_dut (
        .clk(clk), .rst(rst), .mode_en(mode_en), .pwm_busy(pwm_busy),
        .ext_sel_n(ext_sel_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
        .ext_data_in(ext_data_in), .ext_data_out(ext_data_out), .ext_data_oe(ext_data_oe),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
        .irq_clr(irq_clr), .ovf_clr(ovf_clr), .in_full(in_full), .out_full(out_full),
        .overflow(overflow), .irq(irq)
    );

    // ---------------- reference model ----------------
    typedef struct packed {
        logic       s, r, w;
        logic [7:0] d;
    } smp_t;

    smp_t       hist[$];
    int         m_st;       // 0 idle, 1 write, 2 read
    logic [7:0] m_latch, m_wbuf;
    bit         m_ibf, m_obf, m_ovf, m_irq, m_oe;

    always @(posedge clk) begin
        smp_t old;
        bit   wl, rl, en, wend, rstart, rend, rbusy;
        int   nst;
        if (rst) begin
            hist = {};
            hist.push_back('{1'b1, 1'b1, 1'b1, 8'h00});
            hist.push_back('{1'b1, 1'b1, 1'b1, 8'h00});
            m_st = 0; m_latch = 0; m_wbuf = 0;
            m_ibf = 0; m_obf = 0; m_ovf = 0; m_irq = 0; m_oe = 0;
        end else begin
            old    = hist.pop_front();
            hist.push_back('{ext_sel_n, ext_rd_n, ext_wr_n, ext_data_in});
            en     = mode_en && !pwm_busy;
            wl     = !old.s && !old.w;
            rl     = !old.s && !old.r;
            wend   = 0; rstart = 0; rend = 0;
            rbusy  = (m_st == 2);
            nst    = m_st;
            if (m_st == 0) begin
                if (en && wl) nst = 1;
                else if (en && rl) begin nst = 2; rstart = 1; end
            end else if (m_st == 1) begin
                if (!wl) begin nst = 0; wend = 1; end
            end else begin
                if (!rl) begin nst = 0; rend = 1; end
            end
            if (wend && m_ibf) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
            if (wend) m_latch = m_wbuf; else if (cpu_wr) m_latch = cpu_wdata;
            if (nst == 1) m_wbuf = old.d;
            if (wend) m_ibf = 1; else if (cpu_rd) m_ibf = 0;
            if (rstart) m_obf = 0; else if (cpu_wr && !rbusy) m_obf = 1;
            if (wend || rend) m_irq = 1; else if (irq_clr) m_irq = 0;
            m_st = nst;
            m_oe = (nst == 2);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // every-clock comparison against the model (R9 timing covered here)
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(ext_data_oe == m_oe,  "R4/R5 R9 oe",       ext_data_oe, m_oe);
            chk(cpu_rdata == m_latch, "R7 R9 latch",        cpu_rdata, m_latch);
            chk(in_full == m_ibf,     "R3 R9 in_full",      in_full, m_ibf);
            chk(out_full == m_obf,    "R6 out_full",        out_full, m_obf);
            chk(overflow == m_ovf,    "R8 overflow",        overflow, m_ovf);
            chk(irq == m_irq,         "R10 irq",            irq, m_irq);
            if (ext_data_oe) chk(ext_data_out == m_latch, "R4 bus data", ext_data_out, m_latch);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ext_write(input logic [7:0] v);
        @(negedge clk); ext_data_in = v; ext_sel_n = 0; ext_wr_n = 0;
        idle(4);
        ext_wr_n = 1; ext_sel_n = 1;
        idle(4);
    endtask

    task automatic cpu_write(input logic [7:0] v);
        @(negedge clk); cpu_wr = 1; cpu_wdata = v;
        @(negedge clk); cpu_wr = 0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); cpu_rd = 1;
        @(negedge clk); cpu_rd = 0;
    endtask

    task automatic pulse_irq_clr();
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; mode_en = 0; pwm_busy = 0;
        ext_sel_n = 1; ext_rd_n = 1; ext_wr_n = 1; ext_data_in = 0;
        cpu_wr = 0; cpu_wdata = 0; cpu_rd = 0; irq_clr = 0; ovf_clr = 0;
        idle(3);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(!in_full && !out_full && !overflow && !irq, "R1 flags", {in_full,out_full,overflow,irq}, 0);
        chk(!ext_data_oe, "R1 oe", ext_data_oe, 0);

        // R2 disabled: write ignored
        ext_write(8'h77);
        chk(cpu_rdata == 8'h00 && !in_full, "R2 disabled write", cpu_rdata, 0);
        mode_en = 1; pwm_busy = 1;
        ext_write(8'h66);
        chk(cpu_rdata == 8'h00 && !irq, "R2 pwm busy write", cpu_rdata, 0);
        pwm_busy = 0;

        // R3 write
        ext_write(8'hA5);
        chk(cpu_rdata == 8'hA5, "R3 latch", cpu_rdata, 8'hA5);
        chk(in_full && irq, "R3 flags", {in_full, irq}, 2'b11);
        pulse_irq_clr();
        chk(!irq, "R10 clear", irq, 0);
        pulse_rd();
        chk(!in_full, "R7 in_full cleared", in_full, 0);

        // R6 local write outside read
        cpu_write(8'h3C);
        chk(out_full, "R6 out_full set", out_full, 1);

        // R4 read, R6 write during read, R5 release
        @(negedge clk); ext_sel_n = 0; ext_rd_n = 0;
        idle(4);
        chk(ext_data_oe && ext_data_out == 8'h3C, "R4 bus", ext_data_out, 8'h3C);
        chk(!out_full, "R4 out_full cleared", out_full, 0);
        cpu_write(8'hC3);
        chk(ext_data_out == 8'hC3 && ext_data_oe, "R6 bus update", ext_data_out, 8'hC3);
        chk(!out_full, "R6 out_full stays clear", out_full, 0);
        ext_rd_n = 1; ext_sel_n = 1;
        idle(4);
        chk(!ext_data_oe, "R5 released", ext_data_oe, 0);
        chk(irq, "R5 irq", irq, 1);
        idle(5);
        chk(irq, "R10 hold", irq, 1);
        pulse_irq_clr();

        // R8 overflow
        ext_write(8'h11);
        ext_write(8'h22);
        chk(overflow, "R8 set", overflow, 1);
        chk(cpu_rdata == 8'h22, "R8 data replaced", cpu_rdata, 8'h22);
        idle(3);
        chk(overflow, "R8 sticky", overflow, 1);
        @(negedge clk); ovf_clr = 1;
        @(negedge clk); ovf_clr = 0;
        chk(!overflow, "R8 clear", overflow, 0);
        pulse_rd();

        // R11 both strobes low
        @(negedge clk); ext_data_in = 8'h5A; ext_sel_n = 0; ext_rd_n = 0; ext_wr_n = 0;
        idle(4);
        chk(!ext_data_oe, "R11 no drive", ext_data_oe, 0);
        ext_sel_n = 1; ext_rd_n = 1; ext_wr_n = 1;
        idle(4);
        chk(cpu_rdata == 8'h5A && in_full, "R11 write taken", cpu_rdata, 8'h5A);

        // R9 latency: strobe low at negedge, state visible 3 edges later
        pulse_irq_clr();
        @(negedge clk); ext_data_in = 8'h99; ext_sel_n = 0; ext_wr_n = 0;
        idle(2);
        ext_sel_n = 1; ext_wr_n = 1;
        idle(2);
        chk(!irq, "R9 not yet ended", irq, 0);
        @(negedge clk);
        chk(irq && cpu_rdata == 8'h99, "R9 end on time", irq, 1);

        // random mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 7);
            case (op)
                0, 1: ext_write(8'($urandom));
                2: begin
                    @(negedge clk); ext_sel_n = 0; ext_rd_n = 0;
                    idle($urandom_range(3, 6));
                    if ($urandom_range(0, 1) == 1) cpu_write(8'($urandom));
                    ext_rd_n = 1; ext_sel_n = 1;
                    idle(4);
                end
                3: cpu_write(8'($urandom));
                4: pulse_rd();
                5: pulse_irq_clr();
                6: begin @(negedge clk); ovf_clr = 1; @(negedge clk); ovf_clr = 0; end
                default: begin
                    @(negedge clk);
                    mode_en  = ($urandom_range(0, 3) != 0);
                    pwm_busy = ($urandom_range(0, 5) == 0);
                    idle(4);
                end
            endcase
        end
        idle(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule